// File: doc/BRIEF.md
# Banked Multi-Issue Operand Register File

This block is the physical register file behind a wide issue stage. Up to six instructions present their two source register tags each cycle. The 128 physical registers are spread over four banks, and each bank has only three read ports. A register's bank comes from the low bits of its number, so neighbouring register numbers fall in different banks.

Each cycle an arbiter walks the issue slots from the lowest index upward. It admits an instruction only when every operand it names still finds a free port in its bank. An instruction that does not fit gives back everything it would have taken and is reported as stalled, so the issue logic can present it again in the next cycle.

Admitted instructions receive their operand data one clock later from output registers. Each bank also has one write port. Every bank flags the cycles in which more reads were aimed at it than it has ports, and it counts those cycles in a saturating counter.

Top module: `rbf_banked_regfile`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all outputs are zero, all conflict counters read 0, and every register reads back as 0 until it is written.
- R2: Tag bits [1:0] select the bank and bits [6:2] select the entry in that bank. A write on bank port b with entry index e updates physical register e*4+b, and a later granted read of that tag returns the written data.
- R3: No bank serves more than 3 operand reads in one cycle. Two reads on one bank may both be served, and a third one also fits.
- R4: Slots are considered in ascending index order. A requesting slot is granted only if all of its operands fit in the ports left over by lower slots. A slot that does not fit takes no port, so a higher slot may still be granted.
- R5: When an instruction's two valid operands carry the same tag, they take a single port and both return that register's data.
- R6: An operand whose valid bit is low takes no port and returns 0. An instruction with no valid operand is always granted. Every operand of a slot that is not granted returns 0.
- R7: A slot's stall output equals its request and not its grant. A slot that does not request takes no port and shows neither grant nor stall.
- R8: A bank's conflict output is high when the ports demanded of it exceed 3. Demand is the sum, over all requesting slots, of that slot's port need on the bank, counting a shared tag once.
- R9: A bank's conflict counter increases by one in each cycle that the bank's conflict output is raised, and it stays at its all-ones value once it reaches it.
- R10: A read of a register in the same cycle that it is written returns the old contents. The new value is returned from the next cycle on.
- R11: Grant, stall, data and conflict outputs for the inputs presented before a clock edge appear right after that edge and hold for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_SLOTS | Slot is issuing this cycle |
| a_vld_i | input | NUM_SLOTS | First operand present |
| a_tag_i | input | NUM_SLOTS*TAG_W | First operand register tag per slot |
| b_vld_i | input | NUM_SLOTS | Second operand present |
| b_tag_i | input | NUM_SLOTS*TAG_W | Second operand register tag per slot |
| wr_en_i | input | NUM_BANKS | Write enable per bank |
| wr_idx_i | input | NUM_BANKS*IDX_W | Entry index written per bank |
| wr_data_i | input | NUM_BANKS*DATA_W | Write data per bank |
| gnt_o | output | NUM_SLOTS | Slot was served |
| stall_o | output | NUM_SLOTS | Slot lost arbitration and must retry |
| a_data_o | output | NUM_SLOTS*DATA_W | First operand data per slot |
| b_data_o | output | NUM_SLOTS*DATA_W | Second operand data per slot |
| conflict_o | output | NUM_BANKS | Bank was oversubscribed last cycle |
| conflict_cnt_o | output | NUM_BANKS*CNT_W | Saturating conflict cycle count per bank |

## Verification
A bank write and a granted read of the same register can fall in the same cycle. The bench provokes this on purpose and also through random write traffic laid over random reads. The returned value is judged against a bench memory that takes writes only after the edge, so the old value is expected.

Port arbitration and conflict counting also coincide. Directed patterns pile all requests onto one bank, and randomly narrowed tag sets push banks in and out of oversubscription. Grants, stalls, conflict flags and the counters are then compared with a bench port-budget model every cycle.

// File: rtl/rbf_pkg.sv
package rbf_pkg;

   // ports one slot takes on one bank
   function automatic int unsigned ops_on_bank(input logic a_hit, input logic b_hit,
                                                input logic shared);
      return (a_hit ? 1 : 0) + ((b_hit && !shared) ? 1 : 0);
   endfunction

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/rbf_bank.sv
module rbf_bank #(
   parameter int DEPTH  = 32,
   parameter int DATA_W = 32,
   parameter int PORTS  = 3,
   parameter int IDX_W  = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [IDX_W-1:0]        widx,
   input  logic [DATA_W-1:0]       wdata,
   input  logic [PORTS-1:0]        ren,
   input  logic [PORTS*IDX_W-1:0]  ridx,
   output logic [PORTS*DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
      end else if (we) begin
         mem[widx] <= wdata;
      end
   end

   for (genvar p = 0; p < PORTS; p++) begin : g_rport
      assign rdata[p*DATA_W +: DATA_W] = ren[p] ? mem[ridx[p*IDX_W +: IDX_W]] : '0;
   end

endmodule

// File: rtl/rbf_arbiter.sv
module rbf_arbiter import rbf_pkg::*; #(
   parameter int NUM_SLOTS = 6,
   parameter int NUM_BANKS = 4,
   parameter int PORTS     = 3,
   parameter int TAG_W     = 7,
   parameter int BANK_W    = 2,
   parameter int IDX_W     = 5,
   parameter int PSEL_W    = 2
) (
   input  logic [NUM_SLOTS-1:0]             req,
   input  logic [NUM_SLOTS-1:0]             a_vld,
   input  logic [NUM_SLOTS*TAG_W-1:0]       a_tag,
   input  logic [NUM_SLOTS-1:0]             b_vld,
   input  logic [NUM_SLOTS*TAG_W-1:0]       b_tag,
   output logic [NUM_SLOTS-1:0]             gnt,
   output logic [NUM_BANKS-1:0]             conflict,
   output logic [NUM_SLOTS*PSEL_W-1:0]      a_port,
   output logic [NUM_SLOTS*PSEL_W-1:0]      b_port,
   output logic [NUM_BANKS*PORTS-1:0]       pen,
   output logic [NUM_BANKS*PORTS*IDX_W-1:0] pidx
);

   always_comb begin
      int unsigned used [NUM_BANKS];
      int unsigned dem  [NUM_BANKS];
      int unsigned need [NUM_BANKS];
      logic              fit, shared;
      logic [BANK_W-1:0] ba, bb;
      gnt = '0; conflict = '0; a_port = '0; b_port = '0; pen = '0; pidx = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         used[b] = 0; dem[b] = 0; need[b] = 0;
      end
      for (int i = 0; i < NUM_SLOTS; i++) begin
         ba     = a_tag[i*TAG_W +: BANK_W];
         bb     = b_tag[i*TAG_W +: BANK_W];
         shared = a_vld[i] && b_vld[i] && (a_tag[i*TAG_W +: TAG_W] == b_tag[i*TAG_W +: TAG_W]);
         fit    = 1'b1;
         for (int b = 0; b < NUM_BANKS; b++) begin
            need[b] = ops_on_bank(a_vld[i] && (int'(ba) == b), b_vld[i] && (int'(bb) == b), shared);
            if (req[i]) dem[b] = dem[b] + need[b];
            if (used[b] + need[b] > PORTS) fit = 1'b0;
         end
         if (req[i] && fit) begin
            gnt[i] = 1'b1;
            if (a_vld[i]) begin
               for (int p = 0; p < PORTS; p++) begin
                  if (p == used[ba]) begin
                     pen[int'(ba)*PORTS + p] = 1'b1;
                     pidx[(int'(ba)*PORTS + p)*IDX_W +: IDX_W] = a_tag[i*TAG_W + BANK_W +: IDX_W];
                     a_port[i*PSEL_W +: PSEL_W] = PSEL_W'(p);
                  end
               end
               used[ba] = used[ba] + 1;
            end
            if (shared) begin
               b_port[i*PSEL_W +: PSEL_W] = a_port[i*PSEL_W +: PSEL_W];
            end else if (b_vld[i]) begin
               for (int p = 0; p < PORTS; p++) begin
                  if (p == used[bb]) begin
                     pen[int'(bb)*PORTS + p] = 1'b1;
                     pidx[(int'(bb)*PORTS + p)*IDX_W +: IDX_W] = b_tag[i*TAG_W + BANK_W +: IDX_W];
                     b_port[i*PSEL_W +: PSEL_W] = PSEL_W'(p);
                  end
               end
               used[bb] = used[bb] + 1;
            end
         end
      end
      for (int b = 0; b < NUM_BANKS; b++) conflict[b] = (dem[b] > PORTS);
   end

endmodule

// File: rtl/rbf_banked_regfile.sv
module rbf_banked_regfile import rbf_pkg::*; #(
   parameter int NUM_REGS  = 128,
   parameter int NUM_BANKS = 4,
   parameter int PORTS     = 3,
   parameter int NUM_SLOTS = 6,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 16,
   localparam int TAG_W    = $clog2(NUM_REGS),
   localparam int BANK_W   = $clog2(NUM_BANKS),
   localparam int IDX_W    = TAG_W - BANK_W,
   localparam int DEPTH    = NUM_REGS / NUM_BANKS,
   localparam int PSEL_W   = (PORTS > 1) ? $clog2(PORTS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_SLOTS-1:0]        req_i,
   input  logic [NUM_SLOTS-1:0]        a_vld_i,
   input  logic [NUM_SLOTS*TAG_W-1:0]  a_tag_i,
   input  logic [NUM_SLOTS-1:0]        b_vld_i,
   input  logic [NUM_SLOTS*TAG_W-1:0]  b_tag_i,
   input  logic [NUM_BANKS-1:0]        wr_en_i,
   input  logic [NUM_BANKS*IDX_W-1:0]  wr_idx_i,
   input  logic [NUM_BANKS*DATA_W-1:0] wr_data_i,
   output logic [NUM_SLOTS-1:0]        gnt_o,
   output logic [NUM_SLOTS-1:0]        stall_o,
   output logic [NUM_SLOTS*DATA_W-1:0] a_data_o,
   output logic [NUM_SLOTS*DATA_W-1:0] b_data_o,
   output logic [NUM_BANKS-1:0]        conflict_o,
   output logic [NUM_BANKS*CNT_W-1:0]  conflict_cnt_o
);

   if (!is_pow2(NUM_REGS) || !is_pow2(NUM_BANKS) || NUM_BANKS < 2 || NUM_REGS <= NUM_BANKS) begin : g_bad_geometry
      $error("register count and bank count must be powers of two with more registers than banks");
   end
   if (PORTS < 2) begin : g_bad_ports
      $error("each bank needs at least two read ports so one instruction always fits");
   end
   if (NUM_SLOTS < 1 || DATA_W < 1 || CNT_W < 1) begin : g_bad_width
      $error("slot count, data width and counter width must be positive");
   end

   logic [NUM_SLOTS-1:0]             gnt_n;
   logic [NUM_BANKS-1:0]             conf_n;
   logic [NUM_SLOTS*PSEL_W-1:0]      a_port, b_port;
   logic [NUM_BANKS*PORTS-1:0]       pen;
   logic [NUM_BANKS*PORTS*IDX_W-1:0] pidx;
   logic [NUM_BANKS*PORTS*DATA_W-1:0] bank_rd;
   logic [NUM_SLOTS*DATA_W-1:0]      a_nx, b_nx;

   rbf_arbiter #(
      .NUM_SLOTS(NUM_SLOTS), .NUM_BANKS(NUM_BANKS), .PORTS(PORTS), .TAG_W(TAG_W),
      .BANK_W(BANK_W), .IDX_W(IDX_W), .PSEL_W(PSEL_W)
   ) u_arb (
      .req(req_i), .a_vld(a_vld_i), .a_tag(a_tag_i), .b_vld(b_vld_i), .b_tag(b_tag_i),
      .gnt(gnt_n), .conflict(conf_n), .a_port(a_port), .b_port(b_port),
      .pen(pen), .pidx(pidx)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [CNT_W-1:0] cnt_q;

      rbf_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PORTS(PORTS), .IDX_W(IDX_W)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .we(wr_en_i[b]), .widx(wr_idx_i[b*IDX_W +: IDX_W]), .wdata(wr_data_i[b*DATA_W +: DATA_W]),
         .ren(pen[b*PORTS +: PORTS]), .ridx(pidx[b*PORTS*IDX_W +: PORTS*IDX_W]),
         .rdata(bank_rd[b*PORTS*DATA_W +: PORTS*DATA_W])
      );

      always_ff @(posedge clk) begin
         if (!rst_n)                      cnt_q <= '0;
         else if (conf_n[b] && ~&cnt_q)   cnt_q <= cnt_q + 1'b1;
      end
      assign conflict_cnt_o[b*CNT_W +: CNT_W] = cnt_q;
   end

   always_comb begin
      logic [BANK_W-1:0] ba, bb;
      a_nx = '0; b_nx = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         ba = a_tag_i[i*TAG_W +: BANK_W];
         bb = b_tag_i[i*TAG_W +: BANK_W];
         if (gnt_n[i] && a_vld_i[i])
            a_nx[i*DATA_W +: DATA_W] =
               bank_rd[(int'(ba)*PORTS + int'(a_port[i*PSEL_W +: PSEL_W]))*DATA_W +: DATA_W];
         if (gnt_n[i] && b_vld_i[i])
            b_nx[i*DATA_W +: DATA_W] =
               bank_rd[(int'(bb)*PORTS + int'(b_port[i*PSEL_W +: PSEL_W]))*DATA_W +: DATA_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt_o <= '0; stall_o <= '0; a_data_o <= '0; b_data_o <= '0; conflict_o <= '0;
      end else begin
         gnt_o      <= gnt_n;
         stall_o    <= req_i & ~gnt_n;
         a_data_o   <= a_nx;
         b_data_o   <= b_nx;
         conflict_o <= conf_n;
      end
   end

endmodule

// File: rtl/rbf_checker.sv
module rbf_checker #(
   parameter int NUM_SLOTS = 6,
   parameter int NUM_BANKS = 4,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 16
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NUM_SLOTS-1:0]        req_i,
   input logic [NUM_SLOTS-1:0]        gnt_o,
   input logic [NUM_SLOTS-1:0]        stall_o,
   input logic [NUM_SLOTS*DATA_W-1:0] a_data_o,
   input logic [NUM_SLOTS*DATA_W-1:0] b_data_o,
   input logic [NUM_BANKS-1:0]        conflict_o,
   input logic [NUM_BANKS*CNT_W-1:0]  conflict_cnt_o
);

   p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o & stall_o) == '0);

   p_served_or_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o | stall_o) == $past(req_i));

   p_head_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_i[0]) |-> gnt_o[0]);

   p_stall_needs_conflict_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|stall_o) |-> (|conflict_o));

   p_conflict_forces_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|conflict_o) |-> (|stall_o));

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !gnt_o[i] |-> (a_data_o[i*DATA_W +: DATA_W] == '0 && b_data_o[i*DATA_W +: DATA_W] == '0));
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cnt
      p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (conflict_cnt_o[b*CNT_W +: CNT_W] == $past(conflict_cnt_o[b*CNT_W +: CNT_W])) ||
         (conflict_cnt_o[b*CNT_W +: CNT_W] == $past(conflict_cnt_o[b*CNT_W +: CNT_W]) + 1'b1));
   end

endmodule

bind rbf_banked_regfile rbf_checker #(
   .NUM_SLOTS(NUM_SLOTS), .NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_rbf_checker (
   .clk(clk), .rst_n(rst_n), .req_i(req_i), .gnt_o(gnt_o), .stall_o(stall_o),
   .a_data_o(a_data_o), .b_data_o(b_data_o), .conflict_o(conflict_o),
   .conflict_cnt_o(conflict_cnt_o)
);

// File: tb/rbf_banked_regfile_bench.sv
module rbf_banked_regfile_bench;

   localparam int NR = 128, NB = 4, PT = 3, NS = 6, DW = 16, CW = 3;
   localparam int TW = 7, IW = 5;
   localparam time CLK_P = 20ns;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [NS-1:0]    req_i = '0, a_vld_i = '0, b_vld_i = '0;
   logic [NS*TW-1:0] a_tag_i = '0, b_tag_i = '0;
   logic [NB-1:0]    wr_en_i = '0;
   logic [NB*IW-1:0] wr_idx_i = '0;
   logic [NB*DW-1:0] wr_data_i = '0;
   logic [NS-1:0]    gnt_o, stall_o;
   logic [NS*DW-1:0] a_data_o, b_data_o;
   logic [NB-1:0]    conflict_o;
   logic [NB*CW-1:0] conflict_cnt_o;

   rbf_banked_regfile #(.NUM_REGS(NR), .NUM_BANKS(NB), .PORTS(PT), .NUM_SLOTS(NS),
                        .DATA_W(DW), .CNT_W(CW)) u_rbf_banked_regfile (.*);

   always #(CLK_P/2) clk = ~clk;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   // stimulus model
   bit m_req [NS], m_av [NS], m_bv [NS];
   int m_at [NS], m_bt [NS];
   bit m_we [NB];
   int m_wi [NB];
   logic [DW-1:0] m_wd [NB];
   logic [DW-1:0] mem_m [NR];
   int ecnt [NB];

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic clear_in();
      for (int i = 0; i < NS; i++) begin
         m_req[i] = 0; m_av[i] = 0; m_bv[i] = 0; m_at[i] = 0; m_bt[i] = 0;
      end
      for (int b = 0; b < NB; b++) begin
         m_we[b] = 0; m_wi[b] = 0; m_wd[b] = '0;
      end
   endtask

   function automatic logic [DW-1:0] pat(input int r);
      return DW'(r * 613 + 16'h1357);
   endfunction

   // one cycle: drive at negedge, model, check at next negedge
   task automatic step(input string lg, input string ld);
      logic [NS-1:0] eg, es;
      logic [DW-1:0] ea [NS];
      logic [DW-1:0] eb [NS];
      logic [NB-1:0] ec;
      int used [NB];
      int dem [NB];
      int need [NB];
      bit fit, sh;
      for (int i = 0; i < NS; i++) begin
         req_i[i] = m_req[i]; a_vld_i[i] = m_av[i]; b_vld_i[i] = m_bv[i];
         a_tag_i[i*TW +: TW] = TW'(m_at[i]); b_tag_i[i*TW +: TW] = TW'(m_bt[i]);
      end
      for (int b = 0; b < NB; b++) begin
         wr_en_i[b] = m_we[b]; wr_idx_i[b*IW +: IW] = IW'(m_wi[b]); wr_data_i[b*DW +: DW] = m_wd[b];
         used[b] = 0; dem[b] = 0;
      end
      eg = '0; es = '0;
      for (int i = 0; i < NS; i++) begin
         sh = m_av[i] && m_bv[i] && (m_at[i] == m_bt[i]);
         fit = 1;
         for (int b = 0; b < NB; b++) begin
            need[b] = ((m_av[i] && (m_at[i] % NB) == b) ? 1 : 0) +
                      ((m_bv[i] && !sh && (m_bt[i] % NB) == b) ? 1 : 0);
            if (m_req[i]) dem[b] += need[b];
            if (used[b] + need[b] > PT) fit = 0;
         end
         ea[i] = '0; eb[i] = '0;
         if (m_req[i] && fit) begin
            eg[i] = 1'b1;
            for (int b = 0; b < NB; b++) used[b] += need[b];
            if (m_av[i]) ea[i] = mem_m[m_at[i]];
            if (m_bv[i]) eb[i] = mem_m[m_bt[i]];
         end else if (m_req[i]) begin
            es[i] = 1'b1;
         end
      end
      for (int b = 0; b < NB; b++) begin
         ec[b] = (dem[b] > PT);
         if (ec[b] && ecnt[b] < (1 << CW) - 1) ecnt[b]++;
      end
      @(posedge clk);
      for (int b = 0; b < NB; b++) if (m_we[b]) mem_m[m_wi[b] * NB + b] = m_wd[b];
      @(negedge clk);
      chk(lg, "grant", 64'(gnt_o), 64'(eg));
      chk("R7", "stall", 64'(stall_o), 64'(es));
      for (int i = 0; i < NS; i++) begin
         chk(ld, $sformatf("a_data slot%0d", i), 64'(a_data_o[i*DW +: DW]), 64'(ea[i]));
         chk(ld, $sformatf("b_data slot%0d", i), 64'(b_data_o[i*DW +: DW]), 64'(eb[i]));
      end
      chk("R8", "conflict", 64'(conflict_o), 64'(ec));
      for (int b = 0; b < NB; b++)
         chk("R9", $sformatf("count bank%0d", b), 64'(conflict_cnt_o[b*CW +: CW]), 64'(ecnt[b]));
   endtask

   task automatic pile_bank0();
      clear_in();
      for (int i = 0; i < NS; i++) begin
         m_req[i] = 1; m_av[i] = 1; m_bv[i] = 1; m_at[i] = 8 * i; m_bt[i] = 8 * i + 4;
      end
      m_bv[1] = 0;
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int r = 0; r < NR; r++) mem_m[r] = '0;
      for (int b = 0; b < NB; b++) ecnt[b] = 0;
      clear_in();
      repeat (3) @(negedge clk);
      // R1: outputs quiet during reset
      chk("R1", "grant in reset", 64'(gnt_o), 64'd0);
      chk("R1", "counts in reset", 64'(conflict_cnt_o), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "stall after reset", 64'(stall_o), 64'd0);
      chk("R1", "conflict after reset", 64'(conflict_o), 64'd0);
      // R1: every register reads 0 after reset (R11 timing through step)
      for (int k = 0; k < NR / 4; k++) begin
         clear_in();
         m_req[0] = 1; m_av[0] = 1; m_bv[0] = 1; m_at[0] = 4 * k;     m_bt[0] = 4 * k + 1;
         m_req[1] = 1; m_av[1] = 1; m_bv[1] = 1; m_at[1] = 4 * k + 2; m_bt[1] = 4 * k + 3;
         step("R4", "R1");
      end
      // R2: fill through the per-bank write ports
      for (int k = 0; k < NR / NB; k++) begin
         clear_in();
         for (int b = 0; b < NB; b++) begin
            m_we[b] = 1; m_wi[b] = k; m_wd[b] = pat(k * NB + b);
         end
         step("R4", "R2");
      end
      // R2/R11: read back all registers
      for (int k = 0; k < NR / 4; k++) begin
         clear_in();
         m_req[0] = 1; m_av[0] = 1; m_bv[0] = 1; m_at[0] = 4 * k + 3; m_bt[0] = 4 * k + 2;
         m_req[1] = 1; m_av[1] = 1; m_bv[1] = 1; m_at[1] = 4 * k + 1; m_bt[1] = 4 * k;
         step("R11", "R2");
      end
      // R10: write and read the same register in one cycle, then again
      clear_in();
      m_req[0] = 1; m_av[0] = 1; m_at[0] = 5;
      m_we[1] = 1; m_wi[1] = 1; m_wd[1] = 16'hBEEF;
      step("R4", "R10");
      clear_in();
      m_req[0] = 1; m_av[0] = 1; m_at[0] = 5;
      step("R4", "R10");
      // R3: bank 0 oversubscribed, slots 0 and 1 fill its three ports
      pile_bank0();
      step("R3", "R3");
      // R4: a stalled slot releases its ports to a higher slot
      clear_in();
      m_req[0] = 1; m_av[0] = 1; m_bv[0] = 1; m_at[0] = 0;  m_bt[0] = 4;
      m_req[1] = 1; m_av[1] = 1; m_bv[1] = 1; m_at[1] = 8;  m_bt[1] = 2;
      m_req[1] = 1; m_bt[1] = 12;
      m_req[2] = 1; m_av[2] = 1; m_bv[2] = 1; m_at[2] = 16; m_bt[2] = 1;
      step("R4", "R4");
      // R5: identical tags share one port
      clear_in();
      for (int i = 0; i < 4; i++) begin
         m_req[i] = 1; m_av[i] = 1; m_bv[i] = 1; m_at[i] = 20 + 4 * i; m_bt[i] = 20 + 4 * i;
      end
      step("R5", "R5");
      // R6: invalid operands take no port and return zero
      clear_in();
      for (int i = 0; i < 3; i++) begin
         m_req[i] = 1; m_av[i] = 1; m_bv[i] = 0; m_at[i] = 4 * i; m_bt[i] = 4 * i + 40;
      end
      m_req[3] = 1; m_at[3] = 60; m_bt[3] = 64;
      step("R6", "R6");
      // R7: non-requesting slots take no port
      clear_in();
      m_av[0] = 1; m_bv[0] = 1; m_at[0] = 0; m_bt[0] = 4;
      m_req[1] = 1; m_av[1] = 1; m_bv[1] = 1; m_at[1] = 8; m_bt[1] = 12;
      m_req[2] = 1; m_av[2] = 1; m_at[2] = 16;
      step("R7", "R7");
      // R9: saturate bank 0 counter
      for (int n = 0; n < 9; n++) begin
         pile_bank0();
         step("R9", "R3");
      end
      // random traffic with writes overlapping reads (R10, R4, R8)
      for (int n = 0; n < 3000; n++) begin
         int span;
         clear_in();
         span = (n % 3 == 0) ? 8 : NR;
         for (int i = 0; i < NS; i++) begin
            m_req[i] = ($urandom % 4) != 0;
            m_av[i]  = ($urandom % 5) != 0;
            m_bv[i]  = ($urandom % 5) != 0;
            m_at[i]  = int'($urandom % span);
            m_bt[i]  = ($urandom % 6 == 0) ? m_at[i] : int'($urandom % span);
         end
         for (int b = 0; b < NB; b++) begin
            m_we[b] = ($urandom % 2) != 0;
            m_wi[b] = int'($urandom % (NR / NB));
            m_wd[b] = DW'($urandom);
         end
         step("R4", "R10");
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule